// File: doc/BRIEF.md
# Parallel Lane Register Execution Unit

The unit holds a small register file and a set of execution lanes. A lane is described by an operation code, a destination register, two source registers and an enable flag. A host fills registers and lane descriptions through write ports, then pulses `step`. In that single clock every enabled lane computes its result, and the results are written back together. Registers can be read back at any time through a combinational read port.

Each lane computes with the register values held before the step edge. Lanes therefore never see each other's results from the same step, and two lanes can swap registers without a temporary. Arithmetic covers wrap-around binary add, subtract, increment and decrement, three shifts and two unsigned compares. A second family of operations treats a register as a count of consecutive ones starting at bit 0 and adds, subtracts and compares such counts. One lane's description can be copied onto another lane index, and all lanes can be disabled in one command.

Top module: `vlane_exec`

## Requirements
- R1: After reset every register reads zero, every lane is disabled and `done` is low.
- R2: A host write with `reg_wr_en` high updates register `reg_wr_idx` at the clock edge; `rd_data` always shows register `rd_idx`; with no write and no step all registers hold.
- R3: All lanes of a step read both sources from the register values held before that step's edge, never from results written in the same step.
- R4: Code 1 (add) writes src_a + src_b and code 2 (sub) writes src_a + (~src_b + 1), both modulo 2^WIDTH (8-bit: 0x07 + 0x01 = 0x08, 0x07 - 0x01 = 0x06).
- R5: Code 3 (inc) and code 4 (dec) write the destination's own pre-step value plus or minus one, wrapping modulo 2^WIDTH.
- R6: Code 5 shifts src_a left, code 6 shifts it right logically, code 7 shifts it right filling with src_a's top bit, each by the unsigned value of src_b; an amount of WIDTH or more gives all zeros for codes 5 and 6 and all copies of the top bit for code 7.
- R7: Code 8 (a <= b) and code 9 (a >= b) compare unsigned and write 1 or 0 into bit 0 with every other bit cleared; equal operands give 1.
- R8: Codes 10 to 13 read each source as the number of consecutive ones from bit 0; code 10 writes min(WIDTH, a+b) ones, code 11 writes max(0, a-b) ones, code 12 writes 1 when a <= b and code 13 writes 1 when a >= b, else 0, into bit 0.
- R9: A lane whose enable is low, or whose code is 0 (no operation), writes nothing; `clr_all` clears the enable of every lane at the edge, taking priority over any other lane update in that cycle.
- R10: `dup_en` copies the code, both sources and the enable of lane `dup_src` into lane `dup_dst` and sets that lane's destination register to the number `dup_dst`; it overrides a descriptor write to the same lane in that cycle.
- R11: When several enabled lanes write the same register in one step, the highest-numbered lane's result is kept.
- R12: When a host write and a step fall in the same cycle, a lane result replaces the host value on any register a lane writes; a host write to any other register lands normally.
- R13: `done` is high for exactly the cycle after each cycle in which `step` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Host register write enable |
| reg_wr_idx | input | RIDX_W | Register written by the host |
| reg_wr_data | input | WIDTH | Value written by the host |
| rd_idx | input | RIDX_W | Register shown on the read port |
| rd_data | output | WIDTH | Contents of register `rd_idx` |
| cfg_wr_en | input | 1 | Lane descriptor write enable |
| cfg_lane | input | LIDX_W | Lane whose descriptor is written |
| cfg_op | input | 4 | Operation code |
| cfg_dst | input | RIDX_W | Destination register |
| cfg_src_a | input | RIDX_W | First source register |
| cfg_src_b | input | RIDX_W | Second source register |
| cfg_en | input | 1 | Lane enable |
| clr_all | input | 1 | Disable all lanes |
| dup_en | input | 1 | Copy one lane descriptor onto another |
| dup_src | input | LIDX_W | Lane copied from |
| dup_dst | input | LIDX_W | Lane copied to |
| step | input | 1 | Execute all enabled lanes in this cycle |
| done | output | 1 | Pulse one cycle after a step |

## Verification
A host register write and a step can share one clock, so the bench drives both in the same cycle: once with the host aiming at the register a lane increments, where the incremented pre-step value must be read back, and once at an unrelated register, where the host value must appear beside the lane result. Lanes that collide on one destination and lanes that swap registers are provoked in single steps as well, judged by the read port against values worked out from the pre-step contents.

// File: rtl/vlane_pkg.sv
// Package: operation codes shared by the lane datapath and the top level.
// Assumes a 4-bit code field; unlisted codes behave as no operation.
package vlane_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ASR  = 4'd7,
        OP_LE   = 4'd8,
        OP_GE   = 4'd9,
        OP_CADD = 4'd10,
        OP_CSUB = 4'd11,
        OP_CLE  = 4'd12,
        OP_CGE  = 4'd13
    } lane_op_e;
endpackage

// File: rtl/vlane_count_unit.sv
// Count arithmetic: each operand is read as the number of consecutive ones
// starting at bit 0. Sum saturates at WIDTH ones, difference floors at zero.
// Assumes sel: 0 add, 1 subtract, 2 a<=b, 3 a>=b.
module vlane_count_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] res
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] cnt_a, cnt_b;
    logic [CW:0]   fill;

    // Length of the run of ones from bit 0.
    function automatic logic [CW-1:0] run_len(input logic [WIDTH-1:0] v);
        logic          broken;
        logic [CW-1:0] n;
        broken = 1'b0;
        n      = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (!v[i]) broken = 1'b1;
            else if (!broken) n = n + 1'b1;
        end
        return n;
    endfunction

    assign cnt_a = run_len(a);
    assign cnt_b = run_len(b);

    // Number of ones to produce for add or subtract.
    always_comb begin
        if (sel == 2'd0) fill = {1'b0, cnt_a} + {1'b0, cnt_b};
        else if (cnt_a > cnt_b) fill = {1'b0, cnt_a - cnt_b};
        else fill = '0;
    end

    // Build the result word: a run of ones or a single compare bit.
    always_comb begin
        res = '0;
        case (sel)
            2'd2: res[0] = (cnt_a <= cnt_b);
            2'd3: res[0] = (cnt_a >= cnt_b);
            default: begin
                for (int i = 0; i < WIDTH; i++) res[i] = (int'(fill) > i);
            end
        endcase
    end
endmodule

// File: rtl/vlane_alu.sv
// One lane's datapath: combinational result from two source values and the
// destination's own value. wr is low for codes that write nothing.
// Assumes operands are the pre-step register contents.
module vlane_alu
    import vlane_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [WIDTH-1:0] dst_old,
    output logic [WIDTH-1:0] res,
    output logic             wr
);
    logic [WIDTH-1:0] cnt_res;
    logic [1:0]       cnt_sel;
    lane_op_e         opc;

    assign opc = lane_op_e'(op);

    // Map the four count codes onto the count unit's selector.
    always_comb begin
        case (opc)
            OP_CSUB: cnt_sel = 2'd1;
            OP_CLE:  cnt_sel = 2'd2;
            OP_CGE:  cnt_sel = 2'd3;
            default: cnt_sel = 2'd0;
        endcase
    end

    vlane_count_unit #(.WIDTH(WIDTH)) u_count (
        .a   (src_a),
        .b   (src_b),
        .sel (cnt_sel),
        .res (cnt_res)
    );

    // Select the result for the lane's code.
    always_comb begin
        wr  = 1'b1;
        res = '0;
        case (opc)
            OP_ADD: res = src_a + src_b;
            OP_SUB: res = src_a + (~src_b + 1'b1);
            OP_INC: res = dst_old + 1'b1;
            OP_DEC: res = dst_old - 1'b1;
            OP_SHL: res = src_a << src_b;
            OP_SHR: res = src_a >> src_b;
            OP_ASR: res = WIDTH'($signed(src_a) >>> src_b);
            OP_LE:  res[0] = (src_a <= src_b);
            OP_GE:  res[0] = (src_a >= src_b);
            OP_CADD, OP_CSUB, OP_CLE, OP_CGE: res = cnt_res;
            default: wr = 1'b0;
        endcase
    end
endmodule

// File: rtl/vlane_cfg.sv
// Lane descriptor store: code, destination, two sources and enable per lane.
// Order inside one cycle: descriptor write, then copy, then clear of enables.
// Assumes NLANE <= 2**RIDX_W so a lane number fits a register index.
module vlane_cfg #(
    parameter int NLANE  = 4,
    parameter int RIDX_W = 3,
    parameter int LIDX_W = 2,
    parameter int OP_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr_en,
    input  logic [LIDX_W-1:0]             cfg_lane,
    input  logic [OP_W-1:0]               cfg_op,
    input  logic [RIDX_W-1:0]             cfg_dst,
    input  logic [RIDX_W-1:0]             cfg_src_a,
    input  logic [RIDX_W-1:0]             cfg_src_b,
    input  logic                          cfg_en,
    input  logic                          clr_all,
    input  logic                          dup_en,
    input  logic [LIDX_W-1:0]             dup_src,
    input  logic [LIDX_W-1:0]             dup_dst,
    output logic [NLANE-1:0][OP_W-1:0]    lane_op,
    output logic [NLANE-1:0][RIDX_W-1:0]  lane_dst,
    output logic [NLANE-1:0][RIDX_W-1:0]  lane_sa,
    output logic [NLANE-1:0][RIDX_W-1:0]  lane_sb,
    output logic [NLANE-1:0]              lane_en
);
    // Update every lane's descriptor with the fixed priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_op  <= '0;
            lane_dst <= '0;
            lane_sa  <= '0;
            lane_sb  <= '0;
            lane_en  <= '0;
        end else begin
            for (int l = 0; l < NLANE; l++) begin
                if (dup_en && (int'(dup_dst) == l)) begin
                    lane_op[l]  <= lane_op[dup_src];
                    lane_dst[l] <= RIDX_W'(l);
                    lane_sa[l]  <= lane_sa[dup_src];
                    lane_sb[l]  <= lane_sb[dup_src];
                    lane_en[l]  <= lane_en[dup_src] && !clr_all;
                end else if (cfg_wr_en && (int'(cfg_lane) == l)) begin
                    lane_op[l]  <= cfg_op;
                    lane_dst[l] <= cfg_dst;
                    lane_sa[l]  <= cfg_src_a;
                    lane_sb[l]  <= cfg_src_b;
                    lane_en[l]  <= cfg_en && !clr_all;
                end else if (clr_all) begin
                    lane_en[l]  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/vlane_exec.sv
// Top: register file, lane descriptor store and one datapath per lane.
// A step writes every enabled lane's result at one edge; since all lanes
// read the registers before that edge, the register file is its own
// snapshot. Assumes NREG is a power of two and NLANE <= NREG.
module vlane_exec
    import vlane_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int WIDTH = 8,
    parameter int NLANE = 4,
    localparam int RIDX_W = (NREG  > 1) ? $clog2(NREG)  : 1,
    localparam int LIDX_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [RIDX_W-1:0] reg_wr_idx,
    input  logic [WIDTH-1:0]  reg_wr_data,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0]  rd_data,
    input  logic              cfg_wr_en,
    input  logic [LIDX_W-1:0] cfg_lane,
    input  logic [OP_W-1:0]   cfg_op,
    input  logic [RIDX_W-1:0] cfg_dst,
    input  logic [RIDX_W-1:0] cfg_src_a,
    input  logic [RIDX_W-1:0] cfg_src_b,
    input  logic              cfg_en,
    input  logic              clr_all,
    input  logic              dup_en,
    input  logic [LIDX_W-1:0] dup_src,
    input  logic [LIDX_W-1:0] dup_dst,
    input  logic              step,
    output logic              done
);
    logic [NREG-1:0][WIDTH-1:0]    rf_q;
    logic [NREG-1:0][WIDTH-1:0]    rf_d;
    logic [NLANE-1:0][OP_W-1:0]    lane_op;
    logic [NLANE-1:0][RIDX_W-1:0]  lane_dst;
    logic [NLANE-1:0][RIDX_W-1:0]  lane_sa;
    logic [NLANE-1:0][RIDX_W-1:0]  lane_sb;
    logic [NLANE-1:0]              lane_en;
    logic [NLANE-1:0][WIDTH-1:0]   lane_res;
    logic [NLANE-1:0]              lane_wr;
    logic                          done_q;

    vlane_cfg #(
        .NLANE (NLANE),
        .RIDX_W(RIDX_W),
        .LIDX_W(LIDX_W),
        .OP_W  (OP_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr_en(cfg_wr_en),
        .cfg_lane (cfg_lane),
        .cfg_op   (cfg_op),
        .cfg_dst  (cfg_dst),
        .cfg_src_a(cfg_src_a),
        .cfg_src_b(cfg_src_b),
        .cfg_en   (cfg_en),
        .clr_all  (clr_all),
        .dup_en   (dup_en),
        .dup_src  (dup_src),
        .dup_dst  (dup_dst),
        .lane_op  (lane_op),
        .lane_dst (lane_dst),
        .lane_sa  (lane_sa),
        .lane_sb  (lane_sb),
        .lane_en  (lane_en)
    );

    // One datapath per lane, fed from the pre-step register contents.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        vlane_alu #(.WIDTH(WIDTH)) u_alu (
            .op     (lane_op[g]),
            .src_a  (rf_q[lane_sa[g]]),
            .src_b  (rf_q[lane_sb[g]]),
            .dst_old(rf_q[lane_dst[g]]),
            .res    (lane_res[g]),
            .wr     (lane_wr[g])
        );
    end

    // Next register contents: host write first, lanes in rising order after.
    always_comb begin
        rf_d = rf_q;
        if (reg_wr_en) rf_d[reg_wr_idx] = reg_wr_data;
        if (step) begin
            for (int l = 0; l < NLANE; l++) begin
                if (lane_en[l] && lane_wr[l]) rf_d[lane_dst[l]] = lane_res[l];
            end
        end
    end

    // Register file and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q   <= '0;
            done_q <= 1'b0;
        end else begin
            rf_q   <= rf_d;
            done_q <= step;
        end
    end

    assign rd_data = rf_q[rd_idx];
    assign done    = done_q;
endmodule

// File: rtl/vlane_exec_chk.sv
// Checker for vlane_exec: completion pulse, clear, host write and hold.
module vlane_exec_chk #(
    parameter int NREG   = 8,
    parameter int WIDTH  = 8,
    parameter int NLANE  = 4,
    parameter int RIDX_W = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       step,
    input logic                       done,
    input logic                       clr_all,
    input logic                       reg_wr_en,
    input logic [RIDX_W-1:0]          reg_wr_idx,
    input logic [WIDTH-1:0]           reg_wr_data,
    input logic [NLANE-1:0]           lane_en,
    input logic [NREG-1:0][WIDTH-1:0] rf_q
);
    // R13
    step_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> done);
    // R13
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !done);
    // R9
    clear_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (lane_en == '0));
    // R2
    host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !step) |=> (rf_q[$past(reg_wr_idx)] == $past(reg_wr_data)));
    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && !step) |=> $stable(rf_q));
endmodule

bind vlane_exec vlane_exec_chk #(
    .NREG  (NREG),
    .WIDTH (WIDTH),
    .NLANE (NLANE),
    .RIDX_W(RIDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .done       (done),
    .clr_all    (clr_all),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_idx (reg_wr_idx),
    .reg_wr_data(reg_wr_data),
    .lane_en    (lane_en),
    .rf_q       (rf_q)
);

// File: tb/vlane_exec_test.sv
// Directed bench for vlane_exec: one task per scenario.
module vlane_exec_test;
    import vlane_pkg::*;

    localparam int W  = 8;
    localparam int NR = 8;
    localparam int NL = 4;
    localparam int RW = 3;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [RW-1:0] reg_wr_idx = '0;
    logic [W-1:0]  reg_wr_data = '0;
    logic [RW-1:0] rd_idx = '0;
    logic [W-1:0]  rd_data;
    logic          cfg_wr_en = 1'b0;
    logic [LW-1:0] cfg_lane = '0;
    logic [3:0]    cfg_op = '0;
    logic [RW-1:0] cfg_dst = '0;
    logic [RW-1:0] cfg_src_a = '0;
    logic [RW-1:0] cfg_src_b = '0;
    logic          cfg_en = 1'b0;
    logic          clr_all = 1'b0;
    logic          dup_en = 1'b0;
    logic [LW-1:0] dup_src = '0;
    logic [LW-1:0] dup_dst = '0;
    logic          step = 1'b0;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vlane_exec #(.NREG(NR), .WIDTH(W), .NLANE(NL)) uut (.*);

    task automatic check_val(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_reg(string tag, int idx, logic [W-1:0] exp);
        rd_idx = RW'(idx);
        #1;
        check_val($sformatf("%s r%0d", tag, idx), rd_data, exp);
    endtask

    task automatic set_reg(int idx, logic [W-1:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_idx = RW'(idx); reg_wr_data = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_lane(int l, logic [3:0] op, int dst, int sa, int sb, logic en);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_lane = LW'(l); cfg_op = op;
        cfg_dst = RW'(dst); cfg_src_a = RW'(sa); cfg_src_b = RW'(sb); cfg_en = en;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic clear_lanes();
        @(negedge clk);
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
    endtask

    // One step; checks the done pulse (R13).
    task automatic run_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        check_val("R13 done after step", {7'd0, done}, 8'd1);
        @(negedge clk);
        check_val("R13 done drops", {7'd0, done}, 8'd0);
    endtask

    task automatic t_reset();
        for (int r = 0; r < NR; r++) expect_reg("R1 reset", r, 8'h00);
        check_val("R1 done low", {7'd0, done}, 8'd0);
        set_reg(1, 8'h01);
        set_lane(0, OP_ADD, 3, 1, 1, 1'b0);
        run_step();
        expect_reg("R1 lanes disabled", 3, 8'h00);
    endtask

    task automatic t_host_rw();
        set_reg(5, 8'hA5);
        expect_reg("R2 write", 5, 8'hA5);
        expect_reg("R2 neighbour", 4, 8'h00);
    endtask

    task automatic t_add_sub();
        clear_lanes();
        set_reg(1, 8'h07);
        set_reg(2, 8'h01);
        set_lane(0, OP_ADD, 3, 1, 2, 1'b1);
        set_lane(1, OP_SUB, 4, 1, 2, 1'b1);
        run_step();
        expect_reg("R4 add", 3, 8'h08);
        expect_reg("R4 sub", 4, 8'h06);
        set_lane(0, OP_INC, 3, 0, 0, 1'b1);
        set_lane(1, OP_DEC, 4, 0, 0, 1'b1);
        run_step();
        expect_reg("R5 inc", 3, 8'h09);
        expect_reg("R5 dec", 4, 8'h05);
        set_reg(3, 8'hFF);
        set_reg(4, 8'h00);
        run_step();
        expect_reg("R5 inc wrap", 3, 8'h00);
        expect_reg("R5 dec wrap", 4, 8'hFF);
        set_lane(0, OP_SUB, 5, 2, 1, 1'b1);
        set_lane(1, OP_NOP, 0, 0, 0, 1'b0);
        run_step();
        expect_reg("R4 sub wrap", 5, 8'hFA);
    endtask

    task automatic t_snapshot();
        clear_lanes();
        set_reg(0, 8'h00);
        set_reg(1, 8'h03);
        set_reg(2, 8'h09);
        set_lane(0, OP_ADD, 1, 2, 0, 1'b1);
        set_lane(1, OP_ADD, 2, 1, 0, 1'b1);
        run_step();
        expect_reg("R3 swap", 1, 8'h09);
        expect_reg("R3 swap", 2, 8'h03);
    endtask

    task automatic t_shift();
        clear_lanes();
        set_reg(1, 8'h96);
        set_reg(2, 8'h03);
        set_reg(4, 8'h08);
        set_lane(0, OP_SHL, 3, 1, 2, 1'b1);
        set_lane(1, OP_SHR, 5, 1, 2, 1'b1);
        set_lane(2, OP_ASR, 6, 1, 2, 1'b1);
        set_lane(3, OP_ASR, 7, 1, 4, 1'b1);
        run_step();
        expect_reg("R6 shl", 3, 8'hB0);
        expect_reg("R6 shr", 5, 8'h12);
        expect_reg("R6 asr", 6, 8'hF2);
        expect_reg("R6 asr wide", 7, 8'hFF);
        set_lane(0, OP_SHL, 3, 1, 4, 1'b1);
        set_lane(1, OP_SHR, 5, 1, 4, 1'b1);
        run_step();
        expect_reg("R6 shl wide", 3, 8'h00);
        expect_reg("R6 shr wide", 5, 8'h00);
    endtask

    task automatic t_compare();
        clear_lanes();
        set_reg(1, 8'h80);
        set_reg(2, 8'h7F);
        for (int r = 3; r < 7; r++) set_reg(r, 8'hFF);
        set_lane(0, OP_LE, 3, 1, 2, 1'b1);
        set_lane(1, OP_GE, 4, 1, 2, 1'b1);
        set_lane(2, OP_LE, 5, 1, 1, 1'b1);
        set_lane(3, OP_GE, 6, 2, 1, 1'b1);
        run_step();
        expect_reg("R7 le unsigned", 3, 8'h00);
        expect_reg("R7 ge unsigned", 4, 8'h01);
        expect_reg("R7 le equal", 5, 8'h01);
        expect_reg("R7 ge false", 6, 8'h00);
    endtask

    task automatic t_count();
        clear_lanes();
        set_reg(1, 8'h07);
        set_reg(2, 8'h03);
        set_lane(0, OP_CADD, 3, 1, 2, 1'b1);
        set_lane(1, OP_CSUB, 4, 1, 2, 1'b1);
        set_lane(2, OP_CLE, 5, 1, 2, 1'b1);
        set_lane(3, OP_CGE, 6, 1, 2, 1'b1);
        run_step();
        expect_reg("R8 count add", 3, 8'h1F);
        expect_reg("R8 count sub", 4, 8'h01);
        expect_reg("R8 count le", 5, 8'h00);
        expect_reg("R8 count ge", 6, 8'h01);
        set_reg(1, 8'h3F);
        set_reg(2, 8'h1F);
        set_lane(1, OP_CSUB, 4, 2, 1, 1'b1);
        run_step();
        expect_reg("R8 count saturate", 3, 8'hFF);
        expect_reg("R8 count floor", 4, 8'h00);
    endtask

    task automatic t_disable();
        clear_lanes();
        set_reg(1, 8'h01);
        set_reg(3, 8'h33);
        set_reg(4, 8'h44);
        set_reg(5, 8'h55);
        set_lane(0, OP_ADD, 3, 1, 1, 1'b0);
        set_lane(1, OP_NOP, 4, 1, 1, 1'b1);
        run_step();
        expect_reg("R9 disabled lane", 3, 8'h33);
        expect_reg("R9 nop lane", 4, 8'h44);
        set_lane(2, OP_INC, 5, 0, 0, 1'b1);
        clear_lanes();
        run_step();
        expect_reg("R9 cleared lane", 5, 8'h55);
    endtask

    task automatic t_dup();
        clear_lanes();
        set_reg(1, 8'h05);
        set_reg(2, 8'h06);
        set_lane(0, OP_ADD, 7, 1, 2, 1'b1);
        @(negedge clk);
        dup_en = 1'b1; dup_src = 2'd0; dup_dst = 2'd2;
        @(negedge clk);
        dup_en = 1'b0;
        run_step();
        expect_reg("R10 source lane", 7, 8'h0B);
        expect_reg("R10 copied lane", 2, 8'h0B);
    endtask

    task automatic t_same_dst();
        clear_lanes();
        set_reg(1, 8'h05);
        set_reg(2, 8'h06);
        set_lane(0, OP_ADD, 3, 1, 2, 1'b1);
        set_lane(1, OP_SUB, 3, 1, 2, 1'b1);
        set_lane(3, OP_ADD, 3, 1, 1, 1'b1);
        run_step();
        expect_reg("R11 lane 3 wins", 3, 8'h0A);
        set_lane(3, OP_ADD, 3, 1, 1, 1'b0);
        run_step();
        expect_reg("R11 lane 1 wins", 3, 8'hFF);
    endtask

    task automatic t_collide();
        clear_lanes();
        set_reg(3, 8'h10);
        set_lane(0, OP_INC, 3, 0, 0, 1'b1);
        @(negedge clk);
        step = 1'b1; reg_wr_en = 1'b1; reg_wr_idx = 3'd3; reg_wr_data = 8'h55;
        @(negedge clk);
        step = 1'b0; reg_wr_en = 1'b0;
        expect_reg("R12 lane over host", 3, 8'h11);
        @(negedge clk);
        step = 1'b1; reg_wr_en = 1'b1; reg_wr_idx = 3'd6; reg_wr_data = 8'h66;
        @(negedge clk);
        step = 1'b0; reg_wr_en = 1'b0;
        expect_reg("R12 host elsewhere", 6, 8'h66);
        expect_reg("R12 lane alongside", 3, 8'h12);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_host_rw();
        t_add_sub();
        t_snapshot();
        t_shift();
        t_compare();
        t_count();
        t_disable();
        t_dup();
        t_same_dst();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule